// File: doc/BRIEF.md
# Late-Write Pipelined Synchronous SRAM

This block models a synchronous static memory whose word is split into two 9-bit byte lanes, with a shared data bus and a pipeline that has no bus turnaround penalty. A command, an address and the per-lane write strobes are captured on a rising clock edge. Read data leaves the output register two enabled edges later. Write data is taken from the bus two enabled edges after its command. Because both directions have the same latency, reads and writes can follow each other in any order with no idle bus cycle between them.

A pending write is held in the second pipeline stage. It commits at the same edge where a younger read samples the array. When the two addresses match, the read merges in the incoming write data lane by lane. A four-beat burst unit either loads a fresh address or advances on the two low address bits, in linear or interleaved order. The other controls are:
- three chip selects;
- a clock enable that freezes the whole pipeline;
- an output enable that acts without the clock;
- a snooze input that stops new commands from being accepted.

The common bus is presented as `dq_in`, `dq_out` and a drive qualifier `dq_oe`.

Top module: `sram_late_write`

## Requirements
- R1: A read registered at enabled edge k makes `dq_out` show the addressed word with `dq_oe` high from enabled edge k+2 onward, until the next enabled edge. With no read due, `dq_oe` is low.
- R2: `rw_n` low at a load edge registers a write and `rw_n` high registers a read. Write data is sampled from `dq_in` at the second enabled edge after the write command.
- R3: Write strobes `bw_n` are active low. `bw_n[0]` guards lane a (bits 8:0) and `bw_n[1]` guards lane b (bits 17:9). A write with both strobes high changes nothing.
- R4: Commands may be issued on every enabled edge in any mix. A read always returns the result of all earlier writes in command order. This includes a write issued on the immediately preceding edge, which is merged per lane.
- R5: The block is selected only when `ce_a_n`=0, `ce_b`=1 and `ce_c_n`=0. A load edge without selection issues nothing, writes nothing and ends any burst.
- R6: While `clk_en` is low, rising edges have no effect. Commands, bus data, burst state and the output register are all held.
- R7: `oe_n` high forces `dq_oe` low without waiting for a clock edge. `oe_n` low restores it at once.
- R8: `adv`=0 loads a burst from `addr`, and `adv`=1 issues the next beat of the active burst with the loaded operation. With `burst_lin`=1 at load time, the low two address bits step base+1, base+2, base+3, base+4 modulo 4.
- R9: With `burst_lin`=0 at load time, beat n uses low bits base XOR n.
- R10: An advance edge with no active burst, after a deselect or after reset, issues nothing.
- R11: At an edge where `snooze` is high, no command is accepted and the burst state is held. Commands already in flight still complete.
- R12: Synchronous active-low reset clears the pipeline, the output register and the burst state, so `dq_oe` is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clk_en | input | 1 | Clock enable; low holds all state |
| ce_a_n | input | 1 | Chip select, active low |
| ce_b | input | 1 | Chip select, active high |
| ce_c_n | input | 1 | Chip select, active low |
| rw_n | input | 1 | 1 read, 0 write (load edges) |
| bw_n | input | LANES (2) | Per-lane write strobes, active low |
| adv | input | 1 | 0 load address, 1 advance burst |
| burst_lin | input | 1 | 1 linear, 0 interleaved burst order |
| snooze | input | 1 | Blocks new commands while high |
| oe_n | input | 1 | Asynchronous output enable, active low |
| addr | input | AW (8) | Word address |
| dq_in | input | DW (18) | Bus data into the block |
| dq_out | output | DW (18) | Output register contents |
| dq_oe | output | 1 | High when the block drives the bus |

## Verification
All result timing is counted in enabled edges. A read issued at enabled edge k is due on `dq_out` right after enabled edge k+2. Write data for a command issued at edge k is placed on `dq_in` just before edge k+2. The driver counts enabled edges and stamps each expected read with its due edge. The monitor counts the same edges and compares 2 ns after each enabled rising edge. On every other enabled edge it demands that the bus is released, so a late, early or stray output is caught. Frozen cycles advance neither count. The asynchronous output enable is probed directly between edges while the clock is held.

// File: rtl/sram_lw_pkg.sv
// Package: shared command encoding and burst address ordering for the
// late-write SRAM. Assumes bursts of four beats on the two low address bits.
package sram_lw_pkg;

    typedef enum logic {
        OP_READ  = 1'b0,
        OP_WRITE = 1'b1
    } op_e;

    // Low two address bits of burst beat 'step' from 'base'.
    function automatic logic [1:0] burst_low(input logic [1:0] base,
                                             input logic [1:0] step,
                                             input logic       lin);
        return lin ? (base + step) : (base ^ step);
    endfunction

endpackage

// File: rtl/sram_burst_gen.sv
// Burst and command generator: decides per edge whether a command issues,
// with which operation and address. Assumes AW >= 2; write strobes are
// taken fresh each cycle, operation and order are latched at load.
module sram_burst_gen
    import sram_lw_pkg::*;
#(
    parameter int AW    = 8,
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic             sel,
    input  logic             snooze,
    input  logic             adv,
    input  logic             rw_n,
    input  logic             lin_in,
    input  logic [LANES-1:0] bw_n,
    input  logic [AW-1:0]    addr,
    output logic             cmd_v,
    output op_e              cmd_op,
    output logic [AW-1:0]    cmd_addr,
    output logic [LANES-1:0] cmd_bw_n
);

    logic          act_q;
    op_e           op_q;
    logic [AW-1:0] base_q;
    logic [1:0]    cnt_q;
    logic          lin_q;
    logic [1:0]    nxt_cnt;

    assign nxt_cnt  = cnt_q + 2'd1;
    assign cmd_bw_n = bw_n;

    // Purpose: choose the command that this edge would issue.
    always_comb begin
        cmd_v    = 1'b0;
        cmd_op   = op_q;
        cmd_addr = base_q;
        if (!snooze) begin
            if (!adv) begin
                cmd_v    = sel;
                cmd_op   = rw_n ? OP_READ : OP_WRITE;
                cmd_addr = addr;
            end else begin
                cmd_v    = act_q;
                cmd_addr = {base_q[AW-1:2], burst_low(base_q[1:0], nxt_cnt, lin_q)};
            end
        end
    end

    // Purpose: hold or update burst state on enabled edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= 1'b0;
            op_q   <= OP_READ;
            base_q <= '0;
            cnt_q  <= 2'd0;
            lin_q  <= 1'b1;
        end else if (clk_en && !snooze) begin
            if (!adv) begin
                act_q  <= sel;
                op_q   <= rw_n ? OP_READ : OP_WRITE;
                base_q <= addr;
                cnt_q  <= 2'd0;
                lin_q  <= lin_in;
            end else if (act_q) begin
                cnt_q <= nxt_cnt;
            end
        end
    end

    // R8: a linear advance steps the beat counter by one
    a_r8_beat_step: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !snooze && adv && act_q) |=> (cnt_q == $past(cnt_q) + 2'd1));

    // R11: snooze keeps the burst state untouched
    a_r11_hold_burst: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && snooze) |=> ($stable(act_q) && $stable(cnt_q) && $stable(base_q)));

endmodule

// File: rtl/sram_cmd_pipe.sv
// Two-stage command pipeline. Stage 1 is the cycle in which a read samples
// the array; stage 2 is the cycle whose closing edge commits a write and
// loads the output register. Assumes clk_en gates every stage together.
module sram_cmd_pipe
    import sram_lw_pkg::*;
#(
    parameter int AW    = 8,
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic             cmd_v,
    input  op_e              cmd_op,
    input  logic [AW-1:0]    cmd_addr,
    input  logic [LANES-1:0] cmd_bw_n,
    output logic             s1_v,
    output op_e              s1_op,
    output logic [AW-1:0]    s1_addr,
    output logic             s2_v,
    output op_e              s2_op,
    output logic [AW-1:0]    s2_addr,
    output logic [LANES-1:0] s2_bw_n
);

    logic [LANES-1:0] s1_bw_n;

    // Purpose: shift commands one stage per enabled edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_v    <= 1'b0;
            s2_v    <= 1'b0;
            s1_op   <= OP_READ;
            s2_op   <= OP_READ;
            s1_addr <= '0;
            s2_addr <= '0;
            s1_bw_n <= '1;
            s2_bw_n <= '1;
        end else if (clk_en) begin
            s1_v    <= cmd_v;
            s1_op   <= cmd_op;
            s1_addr <= cmd_addr;
            s1_bw_n <= cmd_bw_n;
            s2_v    <= s1_v;
            s2_op   <= s1_op;
            s2_addr <= s1_addr;
            s2_bw_n <= s1_bw_n;
        end
    end

    // R6: a disabled edge leaves the pipeline unchanged
    a_r6_pipe_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> ($stable(s1_v) && $stable(s2_v) && $stable(s2_addr)));

    // R2: a command reaches the commit stage exactly one enabled edge after stage 1
    a_r2_stage_order: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && s1_v) |=> s2_v);

endmodule

// File: rtl/sram_store.sv
// Storage array, one memory per byte lane, with a registered read port.
// A read sampling the array at the edge where a write to the same word
// commits takes the new data for each lane that write enables.
module sram_store #(
    parameter int AW     = 8,
    parameter int LANE_W = 9,
    parameter int LANES  = 2
) (
    input  logic                    clk,
    input  logic                    we,
    input  logic [AW-1:0]           waddr,
    input  logic [LANES-1:0]        wbe_n,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic                    re,
    input  logic [AW-1:0]           raddr,
    output logic [LANES*LANE_W-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic hit;
    assign hit = we && re && (waddr == raddr);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] mem_l [DEPTH];
        logic [LANE_W-1:0] rd_l;

        // Purpose: commit the lane on write; capture the lane on read.
        always_ff @(posedge clk) begin
            if (we && !wbe_n[l]) begin
                mem_l[waddr] <= wdata[l*LANE_W +: LANE_W];
            end
            if (re) begin
                rd_l <= (hit && !wbe_n[l]) ? wdata[l*LANE_W +: LANE_W] : mem_l[raddr];
            end
        end

        assign rdata[l*LANE_W +: LANE_W] = rd_l;
    end

endmodule

// File: rtl/sram_late_write.sv
// Top: late-write pipelined SRAM. Decodes the chip selects, runs commands
// through the two-stage pipeline, and drives the output register. The
// drive qualifier is combinational in oe_n. Assumes that the bus holder
// places write data on dq_in two enabled edges after the command.
module sram_late_write
    import sram_lw_pkg::*;
#(
    parameter int AW     = 8,
    parameter int LANE_W = 9,
    parameter int LANES  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clk_en,
    input  logic                    ce_a_n,
    input  logic                    ce_b,
    input  logic                    ce_c_n,
    input  logic                    rw_n,
    input  logic [LANES-1:0]        bw_n,
    input  logic                    adv,
    input  logic                    burst_lin,
    input  logic                    snooze,
    input  logic                    oe_n,
    input  logic [AW-1:0]           addr,
    input  logic [LANES*LANE_W-1:0] dq_in,
    output logic [LANES*LANE_W-1:0] dq_out,
    output logic                    dq_oe
);

    localparam int DW = LANES * LANE_W;

    logic             sel;
    logic             cmd_v;
    op_e              cmd_op;
    logic [AW-1:0]    cmd_addr;
    logic [LANES-1:0] cmd_bw_n;
    logic             s1_v, s2_v;
    op_e              s1_op, s2_op;
    logic [AW-1:0]    s1_addr, s2_addr;
    logic [LANES-1:0] s2_bw_n;
    logic             we, re;
    logic [DW-1:0]    rd_data;
    logic [DW-1:0]    out_q;
    logic             out_v;

    assign sel = !ce_a_n && ce_b && !ce_c_n;

    sram_burst_gen #(.AW(AW), .LANES(LANES)) burst_i (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .sel(sel),
        .snooze(snooze), .adv(adv), .rw_n(rw_n), .lin_in(burst_lin),
        .bw_n(bw_n), .addr(addr), .cmd_v(cmd_v), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_bw_n(cmd_bw_n)
    );

    sram_cmd_pipe #(.AW(AW), .LANES(LANES)) pipe_i (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .cmd_v(cmd_v),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_bw_n(cmd_bw_n),
        .s1_v(s1_v), .s1_op(s1_op), .s1_addr(s1_addr),
        .s2_v(s2_v), .s2_op(s2_op), .s2_addr(s2_addr), .s2_bw_n(s2_bw_n)
    );

    assign we = clk_en && s2_v && (s2_op == OP_WRITE);
    assign re = clk_en && s1_v && (s1_op == OP_READ);

    sram_store #(.AW(AW), .LANE_W(LANE_W), .LANES(LANES)) store_i (
        .clk(clk), .we(we), .waddr(s2_addr), .wbe_n(s2_bw_n), .wdata(dq_in),
        .re(re), .raddr(s1_addr), .rdata(rd_data)
    );

    // Purpose: load the output register with the read leaving stage 2.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_v <= 1'b0;
            out_q <= '0;
        end else if (clk_en) begin
            out_v <= s2_v && (s2_op == OP_READ);
            if (s2_v && (s2_op == OP_READ)) begin
                out_q <= rd_data;
            end
        end
    end

    assign dq_out = out_q;
    assign dq_oe  = out_v && !oe_n;

    // R1: a read in the commit stage appears in the output register next edge
    a_r1_read_out: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && s2_v && s2_op == OP_READ) |=> out_v);

    // R5: a load edge without full selection issues nothing
    a_r5_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !snooze && !adv && !sel) |=> !s1_v);

    // R11: no command enters the pipeline on a snooze edge
    a_r11_no_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && snooze) |=> !s1_v);

    // R6: the output register holds on a disabled edge
    a_r6_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> ($stable(out_v) && $stable(out_q)));

    // R12: reset releases the bus
    a_r12_reset_idle: assert property (@(posedge clk)
        !rst_n |=> !out_v);

endmodule

// File: tb/sram_late_write_tb_top.sv
// Scoreboard bench: the driver models the requirements and queues the
// expected reads with their due edge; the monitor compares on each
// enabled edge.
module sram_late_write_tb_top;

    localparam int AW = 8;
    localparam int DW = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clk_en = 1'b1;
    logic          ce_a_n = 1'b1, ce_b = 1'b0, ce_c_n = 1'b1;
    logic          rw_n = 1'b1;
    logic [1:0]    bw_n = 2'b11;
    logic          adv = 1'b0, burst_lin = 1'b1, snooze = 1'b0, oe_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] dq_in = '0;
    logic [DW-1:0] dq_out;
    logic          dq_oe;

    always #4 clk = ~clk;

    sram_late_write dut_i (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .ce_a_n(ce_a_n),
        .ce_b(ce_b), .ce_c_n(ce_c_n), .rw_n(rw_n), .bw_n(bw_n), .adv(adv),
        .burst_lin(burst_lin), .snooze(snooze), .oe_n(oe_n), .addr(addr),
        .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    typedef struct {
        int            due;
        logic [DW-1:0] d;
        string         tag;
    } exp_t;

    exp_t          exp_q[$];
    logic [DW-1:0] ref_mem [256];
    int            n_chk = 0, n_fail = 0;
    int            drv_cnt = 0, mon_cnt = 0;
    string         cur_tag = "R12";
    logic          en_now;
    bit            done = 0;
    logic [DW-1:0] d1 = '0, d2 = '0;
    bit            m_act = 0, m_rw = 1, m_lin = 1;
    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_cnt = '0;

    task automatic chk(input bit ok, input string tag,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: count enabled edges and compare results that fall due.
    always @(posedge clk) begin
        en_now = rst_n && clk_en;
        #2;
        if (en_now && !done) begin
            mon_cnt++;
            if (exp_q.size() > 0 && exp_q[0].due == mon_cnt) begin
                exp_t e;
                e = exp_q.pop_front();
                chk(dq_oe === 1'b1 && dq_out === e.d, e.tag,
                    dq_oe ? dq_out : 'x, e.d);
            end else begin
                chk(dq_oe === 1'b0, {cur_tag, " idle bus"}, {17'd0, dq_oe}, '0);
            end
        end
    end

    // Driver: one cycle of stimulus plus the reference model.
    task automatic step(input bit en, input bit ca_n, input bit cb, input bit cc_n,
                        input bit adv_i, input bit rw, input logic [1:0] bw,
                        input bit lin, input bit sn, input logic [AW-1:0] a,
                        input logic [DW-1:0] wd, input string tag);
        bit            iss = 0, irw = 1;
        logic [AW-1:0] ia = '0;
        logic [1:0]    lo;
        cur_tag = tag;
        clk_en = en; ce_a_n = ca_n; ce_b = cb; ce_c_n = cc_n; adv = adv_i;
        rw_n = rw; bw_n = bw; burst_lin = lin; snooze = sn; addr = a;
        dq_in = d2;
        if (en) begin
            drv_cnt++;
            if (!sn) begin
                if (!adv_i) begin
                    iss = !ca_n && cb && !cc_n;
                    ia = a; irw = rw;
                    m_act = iss; m_base = a; m_cnt = 2'd0; m_rw = rw; m_lin = lin;
                end else if (m_act) begin
                    m_cnt = m_cnt + 2'd1;
                    lo = m_lin ? (m_base[1:0] + m_cnt) : (m_base[1:0] ^ m_cnt);
                    ia = {m_base[AW-1:2], lo};
                    iss = 1; irw = m_rw;
                end
            end
            if (iss && irw) begin
                exp_q.push_back('{drv_cnt + 2, ref_mem[ia], tag});
            end
            if (iss && !irw) begin
                if (!bw[0]) ref_mem[ia][8:0]  = wd[8:0];
                if (!bw[1]) ref_mem[ia][17:9] = wd[17:9];
            end
            d2 = d1;
            d1 = (iss && !irw) ? wd : (18'h15A5A ^ DW'(drv_cnt));
        end
        @(negedge clk);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic [1:0] bw, input string tag);
        step(1, 0, 1, 0, 0, 0, bw, 1, 0, a, d, tag);
    endtask

    task automatic rd(input logic [AW-1:0] a, input string tag);
        step(1, 0, 1, 0, 0, 1, 2'b11, 1, 0, a, '0, tag);
    endtask

    task automatic nop(input string tag);
        step(1, 1, 0, 1, 0, 1, 2'b11, 1, 0, '0, '0, tag);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            done = 1;
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(dq_oe === 1'b0, "R12 bus released in reset", {17'd0, dq_oe}, '0);
        rst_n = 1'b1;
        // R12: the first enabled edge after reset must see an idle bus
        nop("R12");
        chk(dq_oe === 1'b0, "R12 idle after reset", {17'd0, dq_oe}, '0);
        // R10: advance straight after reset has no burst to extend
        step(1, 0, 1, 0, 1, 0, 2'b00, 1, 0, 8'h07, 18'h3FFFF, "R10");

        // R2: fill the array with distinct words
        for (int i = 0; i < 256; i++) begin
            wr(AW'(i), DW'(i * 37) ^ 18'h2A5A5, 2'b00, "R2");
        end
        nop("R2"); nop("R2");
        // R1: back-to-back reads of scattered addresses
        for (int i = 0; i < 16; i++) begin
            rd(AW'(i * 13 + 5), "R1");
        end
        nop("R1"); nop("R1");

        // R4: a mixed stream, including a read the very next edge after a write
        wr(8'h50, 18'h11111, 2'b00, "R4");
        rd(8'h50, "R4");
        rd(8'h50, "R4");
        wr(8'h50, 18'h2AAAA, 2'b10, "R4");
        rd(8'h50, "R4");
        wr(8'h51, 18'h03C3C, 2'b01, "R4");
        rd(8'h51, "R4");
        rd(8'h50, "R4");
        nop("R4"); nop("R4");

        // R3: one lane at a time, then no lane at all
        wr(8'h60, 18'h3FFFF, 2'b10, "R3");
        wr(8'h61, 18'h3FFFF, 2'b01, "R3");
        wr(8'h62, 18'h3FFFF, 2'b11, "R3");
        rd(8'h60, "R3"); rd(8'h61, "R3"); rd(8'h62, "R3");
        nop("R3"); nop("R3");

        // R5: each chip select inactive in turn on writes and a read
        step(1, 1, 1, 0, 0, 0, 2'b00, 1, 0, 8'h70, 18'h00001, "R5");
        step(1, 0, 0, 0, 0, 0, 2'b00, 1, 0, 8'h70, 18'h00002, "R5");
        step(1, 0, 1, 1, 0, 0, 2'b00, 1, 0, 8'h70, 18'h00003, "R5");
        step(1, 0, 1, 1, 0, 1, 2'b11, 1, 0, 8'h70, '0, "R5");
        nop("R5"); nop("R5");
        rd(8'h70, "R5");
        nop("R5"); nop("R5");

        // R6: freeze with a write in flight and a read on the bus
        wr(8'h11, 18'h12345, 2'b00, "R6");
        rd(8'h10, "R6");
        nop("R6"); nop("R6");
        step(0, 0, 1, 0, 0, 0, 2'b00, 1, 0, 8'h10, 18'h0BEEF, "R6");
        chk(dq_oe === 1'b1 && dq_out === ref_mem[8'h10], "R6 output held",
            dq_out, ref_mem[8'h10]);
        oe_n = 1'b1; #1;
        chk(dq_oe === 1'b0, "R7 oe_n high releases bus", {17'd0, dq_oe}, '0);
        oe_n = 1'b0; #1;
        chk(dq_oe === 1'b1, "R7 oe_n low drives bus", {17'd0, dq_oe}, 18'd1);
        step(0, 0, 1, 0, 1, 0, 2'b00, 0, 0, 8'h10, 18'h0BEEF, "R6");
        nop("R6"); nop("R6");
        rd(8'h10, "R6"); rd(8'h11, "R6");
        nop("R6"); nop("R6");

        // R8: linear write burst, then a linear read burst
        step(1, 0, 1, 0, 0, 0, 2'b00, 1, 0, 8'h41, 18'h0A0A0, "R8");
        step(1, 1, 0, 1, 1, 1, 2'b00, 0, 0, 8'h00, 18'h0A1A1, "R8");
        step(1, 1, 0, 1, 1, 1, 2'b00, 0, 0, 8'h00, 18'h0A2A2, "R8");
        step(1, 1, 0, 1, 1, 1, 2'b00, 0, 0, 8'h00, 18'h0A3A3, "R8");
        step(1, 0, 1, 0, 0, 1, 2'b11, 1, 0, 8'h43, '0, "R8");
        for (int i = 0; i < 3; i++) step(1, 1, 0, 1, 1, 0, 2'b11, 0, 0, '0, '0, "R8");
        // R9: interleaved read burst
        step(1, 0, 1, 0, 0, 1, 2'b11, 0, 0, 8'h42, '0, "R9");
        for (int i = 0; i < 3; i++) step(1, 1, 0, 1, 1, 0, 2'b11, 1, 0, '0, '0, "R9");
        // R9: interleaved write burst with another start
        step(1, 0, 1, 0, 0, 0, 2'b00, 0, 0, 8'h85, 18'h1B0B0, "R9");
        step(1, 1, 0, 1, 1, 1, 2'b00, 1, 0, 8'h00, 18'h1B1B1, "R9");
        step(1, 1, 0, 1, 1, 1, 2'b00, 1, 0, 8'h00, 18'h1B2B2, "R9");
        rd(8'h84, "R9"); rd(8'h85, "R9"); rd(8'h86, "R9"); rd(8'h87, "R9");
        nop("R9"); nop("R9");

        // R10: advance after a deselect issues nothing
        nop("R10");
        step(1, 0, 1, 0, 1, 0, 2'b00, 1, 0, 8'h30, 18'h3FFFF, "R10");
        step(1, 0, 1, 0, 1, 0, 2'b00, 1, 0, 8'h30, 18'h3FFFF, "R10");
        nop("R10"); nop("R10");
        rd(8'h01, "R10");
        nop("R10"); nop("R10");

        // R11: a read in flight completes; snooze-edge commands are dropped
        rd(8'h20, "R11");
        step(1, 0, 1, 0, 0, 0, 2'b00, 1, 1, 8'h20, 18'h0DEAD, "R11");
        step(1, 0, 1, 0, 0, 1, 2'b11, 1, 1, 8'h21, '0, "R11");
        step(1, 0, 1, 0, 1, 1, 2'b00, 1, 1, 8'h21, 18'h0DEAD, "R11");
        nop("R11"); nop("R11");
        rd(8'h20, "R11"); rd(8'h21, "R11");
        for (int i = 0; i < 4; i++) nop("R11");

        chk(exp_q.size() == 0, "R1 all reads delivered", DW'(exp_q.size()), '0);
        done = 1;
        summary();
        $finish;
    end

endmodule